// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Register File

This block keeps wall-clock time as four separate counters: a 16-bit day count, an hour, a minute and a second. Each pulse on the one-second tick input advances the time by one second. Seconds and minutes roll over at 59 and hours roll over at 23, each carrying into the next field. Software reaches every counter through a small 16-bit register bus that has no wait states. Hour and minute share one register, with the hour in the upper byte and the minute in the lower byte. Because each field has its own register, software can load any one of them without touching the others.

An alarm comparator watches the time as the tick advances it. When the new time equals the programmed alarm day, hour, minute and second, the comparator records an alarm event. The interrupt status register also latches other events:
- the one-second tick,
- nine periodic rates from an external prescaler (2 Hz up to 512 Hz),
- a stopwatch event input.

Status bits are cleared by writing one to them. An enable register masks the status bits one for one, and the single interrupt line is high whenever any enabled status bit is set. A control word and a stopwatch word are stored as plain read/write registers for the surrounding logic.

Top module: `rtc_regfile`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register offsets: 0x00 hour/minute (hour in [15:8], minute in [7:0]), 0x04 seconds (in [5:0]), 0x08 alarm hour/minute (same packing), 0x0C alarm seconds ([5:0]), 0x10 control, 0x14 status, 0x18 enable, 0x1C stopwatch, 0x20 day, 0x24 alarm day. A write loads only the field it addresses, and a read returns the stored value.
- R3: On a cycle with `tick_1hz` high, seconds increment by one. 59 wraps to 0 and increments the minute.
- R4: Minute 59 wraps to 0 and carries into the hour. Hour 23 wraps to 0 and carries into the day.
- R5: The day counter is 16 bits and wraps from 0xFFFF to 0 when it receives a carry.
- R6: A write to the hour/minute, seconds or day register in a tick cycle wins. The written field takes the new value, and the time does not advance in that cycle.
- R7: Status bit 2 (alarm) is set when a tick advances the time to a value whose day, hour, minute and second all equal the alarm registers.
- R8: The status bits are set by these events:

  | Status bit | Event |
  |---|---|
  | 0 | `sw_evt` |
  | 4 | `tick_1hz` |
  | 7 | `rate_ticks[0]` (2 Hz) |
  | 8..15 | `rate_ticks[8:1]` (4 Hz to 512 Hz) |

  Bits 1, 3, 5 and 6 of the status and enable registers always read 0.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: A status bit that is set by an event and cleared by a write in the same cycle stays set.
- R11: `irq` is high exactly when some status bit is set and its enable bit is also set.
- R12: The control and stopwatch registers hold any 16-bit value written to them.
- R13: Reads from undefined offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| rate_ticks | input | 9 | One-cycle pulses of the periodic rates, 2 Hz in bit 0 up to 512 Hz in bit 8 |
| sw_evt | input | 1 | Stopwatch event pulse |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are collisions within a single cycle:
- a time-register write landing on the same edge as a tick,
- a write-one-to-clear landing on the same edge as the event that sets the same bit,
- a carry rippling through all four fields into the 16-bit day wrap.

The stimulus reaches each of these directly. It first loads the fields to just below their limits, such as 23:59:59 on day 0xFFFF, and then issues the tick or the event in the very cycle of the conflicting write. A long sweep of ticks with mixed rate pulses and rotating reads then compares every cycle against a model that keeps the time as one total count of seconds.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 6;
  localparam int SEC_W     = 6;
  localparam int HM_W      = 8;
  localparam int DAY_W     = 16;
  localparam int NUM_RATES = 9;

  localparam logic [ADDR_W-1:0] OFF_HM     = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SEC    = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_AHM    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_ASEC   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_SWATCH = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_DAY    = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ADAY   = 6'h24;

  localparam int BIT_SW    = 0;
  localparam int BIT_ALARM = 2;
  localparam int BIT_TICK  = 4;
  localparam int BIT_RATE0 = 7;

  localparam logic [DATA_W-1:0] EVT_MASK =
      DATA_W'(((1 << NUM_RATES) - 1) << BIT_RATE0) |
      DATA_W'((1 << BIT_SW) | (1 << BIT_ALARM) | (1 << BIT_TICK));

  localparam logic [15:0] SEC_TOP = 16'd59;
  localparam logic [15:0] MIN_TOP = 16'd59;
  localparam logic [15:0] HR_TOP  = 16'd23;
  localparam logic [15:0] DAY_TOP = 16'((1 << DAY_W) - 1);

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HM_W-1:0]  hr;
    logic [HM_W-1:0]  min;
    logic [SEC_W-1:0] sec;
  } rtc_time_t;

  // Returns {carry_out, next_value}; a field at or above its top wraps to 0.
  function automatic logic [16:0] bump(input logic [15:0] v,
                                       input logic [15:0] top,
                                       input logic en);
    if (!en)       return {1'b0, v};
    if (v >= top)  return {1'b1, 16'h0000};
    return {1'b0, v + 16'd1};
  endfunction

  function automatic logic offset_known(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_HM, OFF_SEC, OFF_AHM, OFF_ASEC, OFF_CTRL,
      OFF_STAT, OFF_IEN, OFF_SWATCH, OFF_DAY, OFF_ADAY: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_hm,
  input  logic              ld_sec,
  input  logic              ld_day,
  input  logic [DATA_W-1:0] wdata,
  output rtc_time_t         now,
  output rtc_time_t         upcoming,
  output logic              advance
);
  logic [16:0] s_r, m_r, h_r, d_r;

  always_comb begin
    advance = tick & ~(ld_hm | ld_sec | ld_day);
    s_r = bump(16'(now.sec), SEC_TOP, 1'b1);
    m_r = bump(16'(now.min), MIN_TOP, s_r[16]);
    h_r = bump(16'(now.hr),  HR_TOP,  m_r[16]);
    d_r = bump(16'(now.day), DAY_TOP, h_r[16]);
    upcoming.day = d_r[DAY_W-1:0];
    upcoming.hr  = h_r[HM_W-1:0];
    upcoming.min = m_r[HM_W-1:0];
    upcoming.sec = s_r[SEC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= '0;
    end else if (advance) begin
      now <= upcoming;
    end else begin
      if (ld_hm) begin
        now.hr  <= wdata[2*HM_W-1:HM_W];
        now.min <= wdata[HM_W-1:0];
      end
      if (ld_sec) now.sec <= wdata[SEC_W-1:0];
      if (ld_day) now.day <= wdata[DAY_W-1:0];
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ahm,
  input  logic              ld_asec,
  input  logic              ld_aday,
  input  logic [DATA_W-1:0] wdata,
  input  logic              advance,
  input  rtc_time_t         upcoming,
  output logic [DATA_W-1:0] alm_hm,
  output logic [SEC_W-1:0]  alm_sec,
  output logic [DAY_W-1:0]  alm_day,
  output logic              hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_hm  <= '0;
      alm_sec <= '0;
      alm_day <= '0;
    end else begin
      if (ld_ahm)  alm_hm  <= wdata;
      if (ld_asec) alm_sec <= wdata[SEC_W-1:0];
      if (ld_aday) alm_day <= wdata[DAY_W-1:0];
    end
  end

  always_comb begin
    hit = advance
        && (upcoming.day == alm_day)
        && ({upcoming.hr, upcoming.min} == alm_hm)
        && (upcoming.sec == alm_sec);
  end
endmodule

// File: rtl/rtc_int_ctrl.sv
module rtc_int_ctrl
  import rtc_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              stat_wr,
  input  logic              ien_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);
  logic [DATA_W-1:0] clr_vec;

  always_comb begin
    clr_vec = stat_wr ? (wdata & EVT_MASK) : '0;
    irq     = |(status & enable);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= ((status & ~clr_vec) | set_vec) & EVT_MASK;
      if (ien_wr) enable <= wdata & EVT_MASK;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_1hz,
  input  logic [NUM_RATES-1:0] rate_ticks,
  input  logic                 sw_evt,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq
);
  logic ld_hm, ld_sec, ld_day, ld_ahm, ld_asec, ld_aday;
  logic ctrl_wr, swatch_wr, stat_wr, ien_wr;
  logic time_ld;
  logic tick_applied;
  logic alarm_hit;
  rtc_time_t now, upcoming;
  logic [DATA_W-1:0] alm_hm;
  logic [SEC_W-1:0]  alm_sec;
  logic [DAY_W-1:0]  alm_day;
  logic [DATA_W-1:0] set_vec, status, enable;
  logic [DATA_W-1:0] ctrl_q, swatch_q;

  always_comb begin
    ld_hm     = bus_wr && (bus_addr == OFF_HM);
    ld_sec    = bus_wr && (bus_addr == OFF_SEC);
    ld_day    = bus_wr && (bus_addr == OFF_DAY);
    ld_ahm    = bus_wr && (bus_addr == OFF_AHM);
    ld_asec   = bus_wr && (bus_addr == OFF_ASEC);
    ld_aday   = bus_wr && (bus_addr == OFF_ADAY);
    ctrl_wr   = bus_wr && (bus_addr == OFF_CTRL);
    swatch_wr = bus_wr && (bus_addr == OFF_SWATCH);
    stat_wr   = bus_wr && (bus_addr == OFF_STAT);
    ien_wr    = bus_wr && (bus_addr == OFF_IEN);
    time_ld   = ld_hm | ld_sec | ld_day;
  end

  rtc_timebase u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .ld_hm(ld_hm), .ld_sec(ld_sec), .ld_day(ld_day), .wdata(bus_wdata),
    .now(now), .upcoming(upcoming), .advance(tick_applied)
  );

  rtc_alarm_cmp u_alarm (
    .clk(clk), .rst_n(rst_n),
    .ld_ahm(ld_ahm), .ld_asec(ld_asec), .ld_aday(ld_aday), .wdata(bus_wdata),
    .advance(tick_applied), .upcoming(upcoming),
    .alm_hm(alm_hm), .alm_sec(alm_sec), .alm_day(alm_day), .hit(alarm_hit)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_SW]    = sw_evt;
    set_vec[BIT_ALARM] = alarm_hit;
    set_vec[BIT_TICK]  = tick_1hz;
    for (int i = 0; i < NUM_RATES; i++) set_vec[BIT_RATE0 + i] = rate_ticks[i];
  end

  rtc_int_ctrl u_int (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .stat_wr(stat_wr), .ien_wr(ien_wr), .wdata(bus_wdata),
    .status(status), .enable(enable), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      swatch_q <= '0;
    end else begin
      if (ctrl_wr)   ctrl_q   <= bus_wdata;
      if (swatch_wr) swatch_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_HM:     bus_rdata = {now.hr, now.min};
      OFF_SEC:    bus_rdata = DATA_W'(now.sec);
      OFF_AHM:    bus_rdata = alm_hm;
      OFF_ASEC:   bus_rdata = DATA_W'(alm_sec);
      OFF_CTRL:   bus_rdata = ctrl_q;
      OFF_STAT:   bus_rdata = status;
      OFF_IEN:    bus_rdata = enable;
      OFF_SWATCH: bus_rdata = swatch_q;
      OFF_DAY:    bus_rdata = DATA_W'(now.day);
      OFF_ADAY:   bus_rdata = DATA_W'(alm_day);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_regfile_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick_applied,
  input logic              time_ld,
  input logic              alarm_hit,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] enable,
  input rtc_time_t         now
);
  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_applied && now.sec == 6'd59) |=> (now.sec == 6'd0));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_applied && now.sec < 6'd59) |=> (now.sec == $past(now.sec) + 6'd1));

  // R6
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_SEC) |=> (now.sec == $past(bus_wdata[SEC_W-1:0])));

  // R6
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_applied && !time_ld) |=> ($stable(now.sec) && $stable(now.day)));

  // R7
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> status[BIT_ALARM]);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_STAT)
      |=> ((status & $past(bus_wdata & ~set_vec & EVT_MASK)) == '0));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  // R13
  undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !offset_known(bus_addr) |-> (bus_rdata == '0));
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .tick_applied(tick_applied), .time_ld(time_ld), .alarm_hit(alarm_hit),
  .set_vec(set_vec), .status(status), .enable(enable), .now(now)
);

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint DAYSEC = 86400;
  localparam longint WRAP   = 65536 * 86400;
  localparam int IMPL = 'hFF95;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_1hz = 0;
  logic [8:0]  rate_ticks = '0;
  logic        sw_evt = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [15:0] last_rd;
  logic        last_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regfile u_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .rate_ticks(rate_ticks),
    .sw_evt(sw_evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- reference model: time kept as total seconds
  longint mt;
  int m_ahm, m_asec, m_aday, m_ctrl, m_sw, m_st, m_en;

  function automatic int f_day(longint t); return int'(t / DAYSEC); endfunction
  function automatic int f_hr(longint t);  return int'((t % DAYSEC) / 3600); endfunction
  function automatic int f_min(longint t); return int'((t % 3600) / 60); endfunction
  function automatic int f_sec(longint t); return int'(t % 60); endfunction
  function automatic longint compose(int d, int h, int m, int s);
    return ((longint'(d) * 24 + h) * 60 + m) * 60 + s;
  endfunction

  always @(posedge clk) begin : model
    longint nt;
    int setv, clrv, w;
    bit tw, hit;
    if (!rst_n) begin
      mt = 0; m_ahm = 0; m_asec = 0; m_aday = 0;
      m_ctrl = 0; m_sw = 0; m_st = 0; m_en = 0;
    end else begin
      w  = int'(bus_wdata);
      tw = bus_wr && (bus_addr == 6'h00 || bus_addr == 6'h04 || bus_addr == 6'h20);
      nt = mt;
      hit = 0;
      if (tick_1hz && !tw) begin
        nt  = (mt + 1) % WRAP;
        hit = (f_day(nt) == m_aday) && (((f_hr(nt) << 8) | f_min(nt)) == m_ahm)
              && (f_sec(nt) == m_asec);
      end
      setv = (sw_evt ? 1 : 0) | (hit ? 4 : 0) | (tick_1hz ? 16 : 0);
      for (int i = 0; i < 9; i++) if (rate_ticks[i]) setv |= (1 << (7 + i));
      clrv = (bus_wr && bus_addr == 6'h14) ? (w & IMPL) : 0;
      m_st = ((m_st & ~clrv) | setv) & IMPL;
      mt = nt;
      if (bus_wr) begin
        case (bus_addr)
          6'h00: mt = compose(f_day(mt), w >> 8, w & 255, f_sec(mt));
          6'h04: mt = compose(f_day(mt), f_hr(mt), f_min(mt), w & 63);
          6'h20: mt = compose(w, f_hr(mt), f_min(mt), f_sec(mt));
          6'h08: m_ahm = w;
          6'h0C: m_asec = w & 63;
          6'h10: m_ctrl = w;
          6'h18: m_en = w & IMPL;
          6'h1C: m_sw = w;
          6'h24: m_aday = w;
          default: ;
        endcase
      end
    end
  end

  function automatic int mread(logic [5:0] a);
    case (a)
      6'h00: return (f_hr(mt) << 8) | f_min(mt);
      6'h04: return f_sec(mt);
      6'h08: return m_ahm;
      6'h0C: return m_asec;
      6'h10: return m_ctrl;
      6'h14: return m_st;
      6'h18: return m_en;
      6'h1C: return m_sw;
      6'h20: return f_day(mt);
      6'h24: return m_aday;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // One cycle: drive, compare with the model before the edge, then clock.
  task automatic step(bit wr, logic [5:0] a, logic [15:0] d, bit tk,
                      logic [8:0] rt, bit sw, string tag);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    tick_1hz = tk; rate_ticks = rt; sw_evt = sw;
    #1;
    last_rd  = bus_rdata;
    last_irq = irq;
    chk({tag, " model rdata"}, int'(bus_rdata), mread(a));
    chk({tag, " model irq"}, int'(irq), ((m_st & m_en) != 0) ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d, string tag);
    step(1, a, d, 0, '0, 0, tag);
  endtask

  task automatic rd(logic [5:0] a, int exp, string tag);
    step(0, a, '0, 0, '0, 0, tag);
    chk(tag, int'(last_rd), exp);
  endtask

  task automatic tick(string tag);
    step(0, 6'h3F, '0, 1, '0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset values
    rd(6'h00, 0, "R1 hm"); rd(6'h04, 0, "R1 sec"); rd(6'h14, 0, "R1 stat");
    rd(6'h18, 0, "R1 ien"); rd(6'h20, 0, "R1 day"); rd(6'h24, 0, "R1 aday");
    chk("R1 irq", int'(last_irq), 0);

    // R2: field loads and packing
    wr(6'h00, 16'h0A1E, "R2"); wr(6'h04, 16'd45, "R2"); wr(6'h20, 16'd3, "R2");
    rd(6'h00, 'h0A1E, "R2 hm"); rd(6'h04, 45, "R2 sec"); rd(6'h20, 3, "R2 day");
    wr(6'h08, 16'h1234, "R2"); rd(6'h08, 'h1234, "R2 ahm");
    // R12: plain holding registers
    wr(6'h10, 16'hBEEF, "R12"); wr(6'h1C, 16'h5A5A, "R12");
    rd(6'h10, 'hBEEF, "R12 ctrl"); rd(6'h1C, 'h5A5A, "R12 stopwatch");

    // R3: seconds step and wrap into minute
    tick("R3"); rd(6'h04, 46, "R3 sec step");
    wr(6'h04, 16'd59, "R3"); tick("R3");
    rd(6'h04, 0, "R3 sec wrap"); rd(6'h00, 'h0A1F, "R3 minute carry");

    // R4: full carry into day
    wr(6'h00, 16'h173B, "R4"); wr(6'h04, 16'd59, "R4"); wr(6'h20, 16'd7, "R4");
    tick("R4");
    rd(6'h00, 0, "R4 hm wrap"); rd(6'h04, 0, "R4 sec"); rd(6'h20, 8, "R4 day carry");

    // R5: day wrap
    wr(6'h20, 16'hFFFF, "R5"); wr(6'h00, 16'h173B, "R5"); wr(6'h04, 16'd59, "R5");
    tick("R5"); rd(6'h20, 0, "R5 day wrap");

    // R7 / R11 / R9: alarm event, masking, clearing
    wr(6'h24, 16'd1, "R7"); wr(6'h08, 16'h0000, "R7"); wr(6'h0C, 16'd5, "R7");
    wr(6'h20, 16'd1, "R7"); wr(6'h00, 16'h0000, "R7"); wr(6'h04, 16'd4, "R7");
    wr(6'h14, 16'hFFFF, "R9");
    rd(6'h14, 0, "R9 clear all");
    tick("R7");
    rd(6'h14, 'h0014, "R7 alarm flag");
    chk("R11 irq masked", int'(last_irq), 0);
    wr(6'h18, 16'h0004, "R11");
    rd(6'h14, 'h0014, "R11");
    chk("R11 irq enabled", int'(last_irq), 1);
    wr(6'h14, 16'h0004, "R9");
    rd(6'h14, 'h0010, "R9 w1c");
    chk("R11 irq after clear", int'(last_irq), 0);
    wr(6'h14, 16'h0000, "R9");
    rd(6'h14, 'h0010, "R9 zero write");

    // R8: event sources and unimplemented bits
    step(0, 6'h3F, '0, 0, 9'h1FF, 1, "R8");
    rd(6'h14, 'hFF91, "R8 status");
    wr(6'h18, 16'hFFFF, "R8");
    rd(6'h18, 'hFF95, "R8 enable mask");
    chk("R11 irq any", int'(last_irq), 1);

    // R10: set and clear on the same edge
    wr(6'h14, 16'hFFFF, "R10");
    step(1, 6'h14, 16'h0080, 0, 9'h001, 0, "R10");
    rd(6'h14, 'h0080, "R10 set wins");

    // R6: write beats tick
    step(1, 6'h04, 16'd20, 1, '0, 0, "R6");
    rd(6'h04, 20, "R6 sec load wins"); rd(6'h00, 0, "R6 hm");
    step(1, 6'h20, 16'd2, 1, '0, 0, "R6");
    rd(6'h04, 20, "R6 no advance"); rd(6'h20, 2, "R6 day load");

    // R13: undefined offsets
    rd(6'h02, 0, "R13 read 0x02"); rd(6'h28, 0, "R13 read 0x28"); rd(6'h3E, 0, "R13 read 0x3E");
    wr(6'h28, 16'hFFFF, "R13"); wr(6'h12, 16'hFFFF, "R13");
    rd(6'h10, 'hBEEF, "R13 ctrl intact"); rd(6'h04, 20, "R13 sec intact");

    // R4 sweep: long run of ticks through an hour and day boundary
    wr(6'h14, 16'hFFFF, "R4"); wr(6'h18, 16'h0014, "R4");
    wr(6'h20, 16'd2, "R4"); wr(6'h00, 16'h173A, "R4"); wr(6'h04, 16'd0, "R4");
    for (int i = 0; i < 300; i++) begin
      logic [5:0] a;
      a = 6'((i % 11) * 4);
      step((i % 37) == 36, 6'h14, 16'h0010, (i % 3) != 2, 9'(i * 7), (i % 13) == 0, "R4 sweep");
      step(0, a, '0, 0, '0, 0, "R3 sweep");
    end
    rd(6'h20, 3, "R4 sweep day");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule